// File: doc/BRIEF.md
# Streaming Pixel Simple ALU

This block applies one configurable arithmetic, logic, comparison, shift or clipping operation to every pixel of two input streams, steered by a 2-bit mask stream. The three input streams share one ready signal and advance together. The result leaves on a single output stream with valid/ready flow control. One registered stage lies between the inputs and the output.

Static configuration inputs choose the operation and set the operand width (8 or 16 bits) and signedness. They also hold the constants, the post-operation sign control and the overflow handling. Where mask bit 0 is clear, one raw input passes through untouched. Operands are widened to 2*DW+2 bits before any operation, so every range violation is seen before the overflow handling reduces the result to the output width.

Top module: `pix_alu`

## Requirements
- R1: A beat is accepted on a clock edge where `a_valid`, `b_valid`, `m_valid` and `in_ready` are all high. `out_valid` is high in the following cycle and carries that beat. No output appears while any of the three input valids is low. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R3: When mask bit 0 (`m_data[0]`) is 0, the output is the raw 16-bit `a_data`, or the raw 16-bit `b_data` if `m_data[1]` is 1. This output ignores width, signedness, post control and overflow handling. When `m_data[0]` is 1, the operation selected by `cfg_mode` is applied.
- R4: Operands are taken as `cfg_wide` bits (1: 16 bits, 0: the low 8 bits) and are sign-extended when `cfg_signed` is 1, otherwise zero-extended. The arithmetic modes are: 0 gives a-b, 1 gives b-a, 8 gives a+b, 9 gives a+med, and 10 gives med, where med is `cfg_med`.
- R5: Mode 2 gives min(a,b) and mode 3 gives max(a,b). Modes 4, 5, 6 and 7 give a OR b, a XOR b, a AND b and NOT a. These are computed on the width bits and then extended.
- R6: Mode 12 gives 1 when a ≥ 0, otherwise 0. Mode 14 gives a shifted left by `cfg_shift`. Mode 15 gives a shifted right by `cfg_shift`, filling with the sign bit.
- R7: Mode 16 gives `cfg_val_hi` if a > `cfg_thr_hi`. Otherwise it gives `cfg_val_lo` if a < `cfg_thr_lo`. Otherwise it gives `cfg_med` when `cfg_clip_src` is 0, or a itself when `cfg_clip_src` is 1.
- R8: Mode 17 gives 1 when the comparison holds and 0 otherwise. The `cfg_cmp` codes are 0 for a==b, 1 for a!=b, 2 for a>b, 3 for a<=b, 4 for a<b and 5 for a>=b. Codes 6 and 7 always give 0.
- R9: The result then passes through `cfg_post`: 0 or 3 leaves it unchanged, 1 takes its absolute value, and 2 negates it.
- R10: `cfg_ovf` sets the overflow handling. 0 or 3 saturates to the range [0, 2^w-1] (unsigned) or [-2^(w-1), 2^(w-1)-1] (signed). 1 keeps the low w bits. 2 keeps the low w bits and also clears bit w-1 when signed. In 8-bit mode, bits 15:8 of the output are 0.
- R11: Mode codes 11, 13 and 18 to 31 give 0 when applied. Such a beat with `m_data[0]` set raises `err_flag`, which stays high until reset. The same code with the mask clear leaves `err_flag` unchanged.
- R12: During and after reset, `out_valid` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | First pixel stream valid |
| a_data | input | DW | First pixel |
| b_valid | input | 1 | Second pixel stream valid |
| b_data | input | DW | Second pixel |
| m_valid | input | 1 | Mask stream valid |
| m_data | input | 2 | Mask: bit 0 applies the operation, bit 1 picks the pass-through input |
| in_ready | output | 1 | Shared ready for the three input streams |
| out_valid | output | 1 | Result valid |
| out_data | output | DW | Result pixel |
| out_ready | input | 1 | Downstream ready |
| cfg_mode | input | 5 | Operation code |
| cfg_post | input | 2 | Post control: none, absolute value, negate |
| cfg_cmp | input | 3 | Compare code for mode 17 |
| cfg_shift | input | SHW | Shift amount for modes 14 and 15 |
| cfg_wide | input | 1 | 1: 16-bit data, 0: 8-bit data |
| cfg_signed | input | 1 | 1: signed operands and output range |
| cfg_ovf | input | 2 | Overflow handling: saturate, truncate, truncate without sign |
| cfg_med | input | DW | Median-value constant |
| cfg_clip_src | input | 1 | In-band clip value: 0 is the constant, 1 is the input |
| cfg_thr_hi | input | DW | Upper clip threshold |
| cfg_thr_lo | input | DW | Lower clip threshold |
| cfg_val_hi | input | DW | Value used above the upper threshold |
| cfg_val_lo | input | DW | Value used below the lower threshold |
| err_flag | output | 1 | Sticky flag for an unsupported mode |

## Verification
The assertions assume that the configuration inputs stay still while a beat is in flight. The stimulus therefore changes configuration only after the previous beat has been accepted. The assertions also assume that the producers keep valid and data steady until the shared ready accepts them. The bench drives its beats that way: data and all three valids are held from one falling edge until acceptance. Back-pressure is varied at random, and a partial-valid window checks that one missing stream blocks all progress.

// File: rtl/pix_alu.sv
module pix_alu #(
  parameter int DW  = 16,
  parameter int SHW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  input  logic          m_valid,
  input  logic [1:0]    m_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic [4:0]    cfg_mode,
  input  logic [1:0]    cfg_post,
  input  logic [2:0]    cfg_cmp,
  input  logic [SHW-1:0] cfg_shift,
  input  logic          cfg_wide,
  input  logic          cfg_signed,
  input  logic [1:0]    cfg_ovf,
  input  logic [DW-1:0] cfg_med,
  input  logic          cfg_clip_src,
  input  logic [DW-1:0] cfg_thr_hi,
  input  logic [DW-1:0] cfg_thr_lo,
  input  logic [DW-1:0] cfg_val_hi,
  input  logic [DW-1:0] cfg_val_lo,
  output logic          err_flag
);
  localparam int EW = 2*DW + 2;
  localparam int HW = DW / 2;

  function automatic logic signed [EW-1:0] widen(input logic [DW-1:0] x, input logic wide, input logic sgn);
    logic [DW-1:0] v;
    v = wide ? x : {{HW{sgn & x[HW-1]}}, x[HW-1:0]};
    return {{(EW-DW){sgn & v[DW-1]}}, v};
  endfunction

  logic signed [EW-1:0] ea, eb, emed, ethh, ethl, evh, evl, ebw;
  logic signed [EW-1:0] res, post, sat, rng_hi, rng_lo;
  logic [DW-1:0] bw, shaped, wmask, nxt;
  logic cmp_ok, bad_mode, fire;
  int unsigned wb;

  assign fire     = a_valid & b_valid & m_valid & in_ready;
  assign in_ready = ~out_valid | out_ready;

  assign ea   = widen(a_data, cfg_wide, cfg_signed);
  assign eb   = widen(b_data, cfg_wide, cfg_signed);
  assign emed = widen(cfg_med, cfg_wide, cfg_signed);
  assign ethh = widen(cfg_thr_hi, cfg_wide, cfg_signed);
  assign ethl = widen(cfg_thr_lo, cfg_wide, cfg_signed);
  assign evh  = widen(cfg_val_hi, cfg_wide, cfg_signed);
  assign evl  = widen(cfg_val_lo, cfg_wide, cfg_signed);
  assign ebw  = widen(bw, cfg_wide, cfg_signed);

  always_comb begin
    case (cfg_mode[1:0])
      2'd0:    bw = a_data | b_data;
      2'd1:    bw = a_data ^ b_data;
      2'd2:    bw = a_data & b_data;
      default: bw = ~a_data;
    endcase
  end

  always_comb begin
    case (cfg_cmp)
      3'd0:    cmp_ok = (ea == eb);
      3'd1:    cmp_ok = (ea != eb);
      3'd2:    cmp_ok = (ea >  eb);
      3'd3:    cmp_ok = (ea <= eb);
      3'd4:    cmp_ok = (ea <  eb);
      3'd5:    cmp_ok = (ea >= eb);
      default: cmp_ok = 1'b0;
    endcase
  end

  always_comb begin
    bad_mode = 1'b0;
    case (cfg_mode)
      5'd0:  res = ea - eb;
      5'd1:  res = eb - ea;
      5'd2:  res = (ea < eb) ? ea : eb;
      5'd3:  res = (ea > eb) ? ea : eb;
      5'd4, 5'd5, 5'd6, 5'd7: res = ebw;
      5'd8:  res = ea + eb;
      5'd9:  res = ea + emed;
      5'd10: res = emed;
      5'd12: res = (ea >= 0) ? EW'(1) : '0;
      5'd14: res = ea <<< cfg_shift;
      5'd15: res = ea >>> cfg_shift;
      5'd16: res = (ea > ethh) ? evh : (ea < ethl) ? evl : (cfg_clip_src ? ea : emed);
      5'd17: res = cmp_ok ? EW'(1) : '0;
      default: begin
        res      = '0;
        bad_mode = 1'b1;
      end
    endcase
  end

  always_comb begin
    case (cfg_post)
      2'd1:    post = (res < 0) ? -res : res;
      2'd2:    post = -res;
      default: post = res;
    endcase
  end

  always_comb begin
    wb     = cfg_wide ? DW : HW;
    rng_hi = (EW'(1) << (wb - int'(cfg_signed))) - EW'(1);
    rng_lo = cfg_signed ? -(EW'(1) << (wb - 1)) : '0;
    sat    = (post > rng_hi) ? rng_hi : (post < rng_lo) ? rng_lo : post;
    wmask  = cfg_wide ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
    case (cfg_ovf)
      2'd1:    shaped = post[DW-1:0] & wmask;
      2'd2:    shaped = post[DW-1:0] & wmask & ~(DW'(cfg_signed) << (wb - 1));
      default: shaped = sat[DW-1:0] & wmask;
    endcase
    nxt = m_data[0] ? shaped : (m_data[1] ? b_data : a_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      err_flag  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= nxt;
        if (m_data[0] && bad_mode) err_flag <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  rise_needs_all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(a_valid && b_valid && m_valid));

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !m_data[0] |=> out_data == $past(m_data[1] ? b_data : a_data));

  // R8
  compare_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && m_data[0] && cfg_mode == 5'd17 && cfg_post == 2'd0 |=> out_data <= DW'(1));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

// File: tb/pix_alu_tb.sv
`timescale 1ns/1ps
module pix_alu_tb;
  logic clk = 0, rst_n = 0;
  logic a_valid = 0, b_valid = 0, m_valid = 0;
  logic [15:0] a_data = 0, b_data = 0;
  logic [1:0] m_data = 0;
  logic in_ready, out_valid, out_ready = 1, err_flag;
  logic [15:0] out_data;
  logic [4:0] cfg_mode = 0;
  logic [1:0] cfg_post = 0, cfg_ovf = 0;
  logic [2:0] cfg_cmp = 0;
  logic [3:0] cfg_shift = 0;
  logic cfg_wide = 1, cfg_signed = 0, cfg_clip_src = 0;
  logic [15:0] cfg_med = 0, cfg_thr_hi = 0, cfg_thr_lo = 0, cfg_val_hi = 0, cfg_val_lo = 0;

  int checks = 0, errors = 0;
  bit done = 0, bp_en = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pix_alu u_dut (.clk, .rst_n, .a_valid, .a_data, .b_valid, .b_data, .m_valid, .m_data,
    .in_ready, .out_valid, .out_data, .out_ready, .cfg_mode, .cfg_post, .cfg_cmp,
    .cfg_shift, .cfg_wide, .cfg_signed, .cfg_ovf, .cfg_med, .cfg_clip_src,
    .cfg_thr_hi, .cfg_thr_lo, .cfg_val_hi, .cfg_val_lo, .err_flag);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [15:0] x, input longint w, input bit s);
    longint v;
    v = longint'(x) & ((64'sd1 <<< w) - 1);
    if (s && v >= (64'sd1 <<< (w - 1))) v = v - (64'sd1 <<< w);
    return v;
  endfunction

  function automatic logic [15:0] model(input logic [15:0] a, b, input logic [1:0] m);
    longint w, r, ea, eb, md, hi, lo;
    bit s;
    if (!m[0]) return m[1] ? b : a;
    w = cfg_wide ? 16 : 8; s = cfg_signed;
    ea = sx(a, w, s); eb = sx(b, w, s); md = sx(cfg_med, w, s);
    case (cfg_mode)
      0: r = ea - eb;
      1: r = eb - ea;
      2: r = ea < eb ? ea : eb;
      3: r = ea > eb ? ea : eb;
      4: r = sx(a | b, w, s);
      5: r = sx(a ^ b, w, s);
      6: r = sx(a & b, w, s);
      7: r = sx(~a, w, s);
      8: r = ea + eb;
      9: r = ea + md;
      10: r = md;
      12: r = ea >= 0 ? 1 : 0;
      14: r = ea <<< cfg_shift;
      15: r = ea >>> cfg_shift;
      16: r = ea > sx(cfg_thr_hi, w, s) ? sx(cfg_val_hi, w, s) :
              ea < sx(cfg_thr_lo, w, s) ? sx(cfg_val_lo, w, s) : (cfg_clip_src ? ea : md);
      17: case (cfg_cmp)
            0: r = ea == eb; 1: r = ea != eb; 2: r = ea > eb;
            3: r = ea <= eb; 4: r = ea < eb; 5: r = ea >= eb; default: r = 0;
          endcase
      default: r = 0;
    endcase
    if (cfg_post == 1 && r < 0) r = -r;
    else if (cfg_post == 2) r = -r;
    hi = s ? (64'sd1 <<< (w - 1)) - 1 : (64'sd1 <<< w) - 1;
    lo = s ? -(64'sd1 <<< (w - 1)) : 0;
    if (cfg_ovf == 1) r = r & ((64'sd1 <<< w) - 1);
    else if (cfg_ovf == 2) r = r & ((64'sd1 <<< (w - s)) - 1);
    else begin
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      r = r & ((64'sd1 <<< w) - 1);
    end
    return 16'(r);
  endfunction

  task automatic send(input logic [15:0] a, b, input logic [1:0] m,
                      input logic [15:0] exp, input string req);
    a_data = a; b_data = b; m_data = m;
    a_valid = 1; b_valid = 1; m_valid = 1;
    forever begin
      if (in_ready) begin
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    a_valid = 0; b_valid = 0; m_valid = 0;
  endtask

  task automatic sendm(input logic [15:0] a, b, input logic [1:0] m, input string req);
    send(a, b, m, model(a, b, m), req);
  endtask

  task automatic drain;
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    chk("R1 drain", 16'(exp_q.size()), 16'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R1 unexpected output", out_data, 16'hxxxx);
      else chk(tag_q.pop_front(), out_data, exp_q.pop_front());
    end
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = bp_en ? 1'($urandom % 2) : 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int modes[16] = '{0,1,2,3,4,5,6,7,8,9,10,12,14,15,16,17};
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", 16'(out_valid), 16'd0);
    chk("R12 err in reset", 16'(err_flag), 16'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 out_valid after reset", 16'(out_valid), 16'd0);

    // R4 arithmetic, R10 saturation/truncation
    cfg_mode = 0; send(5, 9, 1, 16'h0000, "R4 mode0 unsigned sat");
    cfg_ovf = 1;  send(5, 9, 1, 16'hFFFC, "R10 mode0 truncate");
    cfg_ovf = 0; cfg_mode = 1; send(5, 9, 1, 16'h0004, "R4 mode1");
    cfg_mode = 8; send(16'hFFF0, 16'h0020, 1, 16'hFFFF, "R10 add saturate");
    cfg_ovf = 1; send(16'hFFF0, 16'h0020, 1, 16'h0010, "R10 add truncate");
    cfg_ovf = 0; cfg_med = 100; cfg_mode = 9; send(7, 0, 1, 16'd107, "R4 mode9");
    cfg_mode = 10; send(16'h5555, 0, 1, 16'd100, "R4 mode10");
    // R5
    cfg_signed = 1; cfg_mode = 2; send(16'hFFFE, 3, 1, 16'hFFFE, "R5 signed min");
    cfg_mode = 3; send(16'hFFFE, 3, 1, 16'h0003, "R5 signed max");
    cfg_signed = 0; cfg_wide = 0; cfg_mode = 7; send(16'h12F0, 0, 1, 16'h000F, "R5 narrow not");
    cfg_mode = 4; send(16'h0F0F, 16'h00F0, 1, 16'h00FF, "R5 narrow or");
    // R6
    cfg_wide = 1; cfg_signed = 1; cfg_mode = 12; send(16'h8000, 0, 1, 16'h0000, "R6 sign neg");
    send(16'h0000, 0, 1, 16'h0001, "R6 sign zero");
    cfg_signed = 0; cfg_mode = 14; cfg_shift = 4; send(16'h0123, 0, 1, 16'h1230, "R6 shl");
    send(16'h1234, 0, 1, 16'hFFFF, "R6 shl saturate");
    cfg_signed = 1; cfg_mode = 15; send(16'hFF00, 0, 1, 16'hFFF0, "R6 arith shr");
    // R7
    cfg_signed = 0; cfg_mode = 16; cfg_thr_hi = 200; cfg_thr_lo = 50;
    cfg_val_hi = 1000; cfg_val_lo = 7; cfg_med = 99;
    send(300, 0, 1, 16'd1000, "R7 above");
    send(10, 0, 1, 16'd7, "R7 below");
    send(120, 0, 1, 16'd99, "R7 band const");
    send(200, 0, 1, 16'd99, "R7 at upper threshold");
    cfg_clip_src = 1; send(120, 0, 1, 16'd120, "R7 band input");
    // R8
    cfg_mode = 17;
    for (int c = 0; c < 8; c++) begin
      cfg_cmp = 3'(c);
      send(3, 5, 1, (c == 1 || c == 3 || c == 4) ? 16'd1 : 16'd0, "R8 cmp 3 vs 5");
      send(5, 5, 1, (c == 0 || c == 3 || c == 5) ? 16'd1 : 16'd0, "R8 cmp 5 vs 5");
    end
    // R9
    cfg_signed = 1; cfg_mode = 0; send(3, 10, 1, 16'hFFF9, "R9 none");
    cfg_post = 1; send(3, 10, 1, 16'h0007, "R9 abs");
    cfg_post = 2; send(3, 10, 1, 16'h0007, "R9 neg");
    cfg_mode = 10; cfg_med = 5; send(0, 0, 1, 16'hFFFB, "R9 neg signed");
    cfg_signed = 0; send(0, 0, 1, 16'h0000, "R9 neg unsigned sat");
    cfg_post = 0;
    // R10 narrow signed
    cfg_wide = 0; cfg_signed = 1; cfg_mode = 8;
    send(100, 100, 1, 16'h007F, "R10 narrow signed sat");
    cfg_ovf = 1; send(100, 100, 1, 16'h00C8, "R10 narrow truncate");
    cfg_ovf = 2; send(100, 100, 1, 16'h0048, "R10 truncate no sign");
    cfg_ovf = 0; cfg_mode = 0; send(16'h0080, 1, 1, 16'h0080, "R10 narrow signed low sat");
    // R3
    send(16'h1234, 16'hBEEF, 2'b00, 16'h1234, "R3 pass a");
    send(16'h1234, 16'hBEEF, 2'b10, 16'hBEEF, "R3 pass b");
    // R11
    cfg_wide = 1; cfg_signed = 0; cfg_mode = 11;
    send(16'h4321, 0, 2'b00, 16'h4321, "R11 masked-off bad mode");
    drain();
    chk("R11 err stays low", 16'(err_flag), 16'd0);
    send(16'h4321, 7, 2'b01, 16'h0000, "R11 bad mode zero");
    drain();
    chk("R11 err set", 16'(err_flag), 16'd1);
    cfg_mode = 0; send(9, 5, 1, 16'd4, "R11 after err");
    drain();
    chk("R11 err sticky", 16'(err_flag), 16'd1);
    // R1 partial valids
    a_valid = 1; b_valid = 1; m_valid = 0;
    repeat (5) @(negedge clk);
    a_valid = 0; m_valid = 1;
    repeat (5) @(negedge clk);
    m_valid = 0; b_valid = 0;
    chk("R1 no output on partial valid", 16'(out_valid), 16'd0);
    // R1/R2 random with back-pressure
    bp_en = 1;
    for (int i = 0; i < 400; i++) begin
      cfg_mode = 5'(modes[$urandom % 16]);
      cfg_post = 2'($urandom); cfg_cmp = 3'($urandom); cfg_shift = 4'($urandom);
      cfg_wide = 1'($urandom); cfg_signed = 1'($urandom); cfg_ovf = 2'($urandom);
      cfg_med = 16'($urandom); cfg_clip_src = 1'($urandom);
      cfg_thr_hi = 16'($urandom); cfg_thr_lo = 16'($urandom);
      cfg_val_hi = 16'($urandom); cfg_val_lo = 16'($urandom);
      sendm(16'($urandom), 16'($urandom), 2'($urandom | ($urandom % 4 != 0)), "R2 random");
      if (i % 8 == 0) drain();
    end
    drain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule